// File: doc/BRIEF.md
# Parallel Ramp-Compare Conversion Controller

This block sequences a single-slope conversion of many stored analog samples at the same time. A start request resets a shared 12-bit count to zero and then advances it by one every clock. The same count is driven out as the code for an external ramp DAC, so the ramp voltage and the count rise together. Every storage cell has its own comparator. When a comparator reports that the ramp has crossed its stored sample, that cell's register takes a copy of the shared count. At the end of the ramp, all cells hold their digital results together.

Comparator outputs arrive as asynchronous digital levels. Each one passes through a two-stage synchronizer, and only its first rising edge inside a conversion is used. A cell that never fires by full scale is given the full-scale code and is flagged as overranged. The end of a conversion is marked by a single-cycle done pulse. At that point the controller is idle again and can accept a new start.

Top module: `wilk_conv_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, busy_o, done_o, ramp_o, every cell code and every overrange flag are zero.
- R2: A start_i sampled high while idle sets busy_o from the next cycle. In that same cycle ramp_o reads 0, and every cell code and overrange flag reads 0.
- R3: While busy, ramp_o goes up by exactly one per clock from 0 to 4095. Whenever busy_o is low, ramp_o is 0.
- R4: Take a comparator input that goes high before clock edge k after having been low. Its cell stores, at edge k+2, the ramp_o value shown between edges k+1 and k+2. Cell i occupies code_o bits [12*i+11 : 12*i]. Cells that fire together store equal codes.
- R5: Only the first rising comparator edge in a conversion is stored. Later falls and rises on that cell leave its code unchanged.
- R6: A comparator that is already high when the conversion starts, and stays high, produces no capture.
- R7: A cell with no capture by the cycle in which ramp_o shows 4095 receives code 4095 and sets its overrange bit (ovf_o bit i for cell i). A cell whose capture lands in that same cycle receives 4095 with its overrange bit clear.
- R8: done_o is high for exactly one cycle: the cycle after the one in which ramp_o showed 4095. busy_o is low in that cycle.
- R9: A start_i pulse while busy has no effect. The ramp keeps counting and busy_o stays high.
- R10: After a conversion, cell codes and overrange bits hold their values until the next accepted start, whatever the comparators do in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to begin a conversion |
| cmp_i | input | N_CELLS | Asynchronous comparator level, one per cell |
| ramp_o | output | CNT_W | Code for the ramp DAC, equal to the shared count |
| busy_o | output | 1 | A conversion is in progress |
| done_o | output | 1 | One-cycle end-of-conversion pulse |
| code_o | output | N_CELLS*CNT_W | Stored code of every cell, cell 0 in the low bits |
| ovf_o | output | N_CELLS | Per-cell overrange flag |

## Verification
The assertions assume that each comparator input is a level signal with no timing relation to the clock. They assume nothing about how often it toggles, because the synchronizer output is checked only for edges that come at least two cycles apart. The stimulus changes comparator inputs and start only on the falling clock edge, so each change is sampled on a definite rising edge. Before each new conversion the stimulus holds every comparator low for several cycles. This lets the synchronizer settle, so an edge belongs to the conversion in which it was driven.

// File: rtl/wilk_pkg.sv
package wilk_pkg;
    // Controller phase: waiting for start, or ramp in progress.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/wilk_edge_sync.sv
module wilk_edge_sync #(
    parameter int N_CELLS = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CELLS-1:0] cmp_i,
    output logic [N_CELLS-1:0] rise_o
);
    typedef struct packed {
        logic [N_CELLS-1:0] meta;
        logic [N_CELLS-1:0] sync;
        logic [N_CELLS-1:0] prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = cmp_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.sync & ~st_q.prev;

    // R4: a synchronized edge cannot repeat on the same cell in back-to-back cycles
    rise_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/wilk_cell_latch.sv
module wilk_cell_latch #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic             last_i,
    input  logic             rise_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] code_o,
    output logic             ovf_o
);
    typedef struct packed {
        logic [CNT_W-1:0] code;
        logic             hit;
        logic             ovf;
    } cell_st_t;

    cell_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d = '0;
        end else if (run_i && !st_q.hit) begin
            if (rise_i) begin
                st_d.code = count_i;
                st_d.hit  = 1'b1;
            end else if (last_i) begin
                st_d.code = '1;
                st_d.ovf  = 1'b1;
                st_d.hit  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign code_o = st_q.code;
    assign ovf_o  = st_q.ovf;

    // R7
    ovf_full_scale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (code_o == '1));

    // R5
    hold_after_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.hit && !clear_i) |=> $stable(code_o));
endmodule

// File: rtl/wilk_conv_ctrl.sv
module wilk_conv_ctrl
    import wilk_pkg::*;
#(
    parameter int N_CELLS = 16,
    parameter int CNT_W   = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [N_CELLS-1:0]       cmp_i,
    output logic [CNT_W-1:0]         ramp_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [N_CELLS*CNT_W-1:0] code_o,
    output logic [N_CELLS-1:0]       ovf_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    clear_d;
    logic    run_w;
    logic    last_w;
    logic [N_CELLS-1:0] rise_w;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        clear_d   = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.phase = PH_RUN;
                    st_d.cnt   = '0;
                    clear_d    = 1'b1;
                end
            end
            PH_RUN: begin
                if (st_q.cnt == CNT_MAX) begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                    st_d.done  = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_w  = (st_q.phase == PH_RUN);
    assign last_w = run_w && (st_q.cnt == CNT_MAX);

    wilk_edge_sync #(.N_CELLS(N_CELLS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmp_i  (cmp_i),
        .rise_o (rise_w)
    );

    for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
        wilk_cell_latch #(.CNT_W(CNT_W)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear_d),
            .run_i   (run_w),
            .last_i  (last_w),
            .rise_i  (rise_w[g]),
            .count_i (st_q.cnt),
            .code_o  (code_o[g*CNT_W +: CNT_W]),
            .ovf_o   (ovf_o[g])
        );
    end

    assign ramp_o = st_q.cnt;
    assign busy_o = run_w;
    assign done_o = st_q.done;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R8
    done_after_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ramp_o == CNT_MAX) |=> (done_o && !busy_o));

    // R3 and R9: counting continues regardless of start while busy
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && ramp_o != CNT_MAX) |=> (busy_o && ramp_o == CNT_W'($past(ramp_o) + 1'b1)));

    // R3
    ramp_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (ramp_o == '0));

    // R2
    start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && ovf_o == '0 && code_o == '0));
endmodule

// File: tb/test_wilk_conv_ctrl.sv
module test_wilk_conv_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 16;
    localparam int W   = 12;
    localparam int MAX = 4095;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [N-1:0]     cmp = '0;
    logic [W-1:0]     ramp;
    logic             busy;
    logic             done;
    logic [N*W-1:0]   code;
    logic [N-1:0]     ovf;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wilk_conv_ctrl #(.N_CELLS(N), .CNT_W(W)) i_wilk_conv_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .cmp_i   (cmp),
        .ramp_o  (ramp),
        .busy_o  (busy),
        .done_o  (done),
        .code_o  (code),
        .ovf_o   (ovf)
    );

    task automatic chk_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int cell_code(input int i);
        return int'(code[i*W +: W]);
    endfunction

    // Behavioural reference: input history queue plus per-cell results
    bit [N-1:0] hist[$];
    int  m_cnt;
    bit  m_busy, m_done;
    int  m_code[N];
    bit  m_cap[N];
    bit  m_ovf[N];

    always @(posedge clk) begin
        bit [N-1:0] rise;
        if (!rst_n) begin
            hist = {};
            for (int k = 0; k < 3; k++) hist.push_back('0);
            m_cnt = 0; m_busy = 0; m_done = 0;
            for (int c = 0; c < N; c++) begin m_code[c] = 0; m_cap[c] = 0; m_ovf[c] = 0; end
        end else begin
            hist.push_front(cmp);
            while (hist.size() > 4) void'(hist.pop_back());
            rise = hist[2] & ~hist[3];
            if (m_busy) begin
                m_done = 0;
                for (int c = 0; c < N; c++)
                    if (!m_cap[c] && rise[c]) begin m_code[c] = m_cnt; m_cap[c] = 1; end
                if (m_cnt == MAX) begin
                    for (int c = 0; c < N; c++)
                        if (!m_cap[c]) begin m_code[c] = MAX; m_ovf[c] = 1; m_cap[c] = 1; end
                    m_busy = 0; m_done = 1; m_cnt = 0;
                end else begin
                    m_cnt++;
                end
            end else begin
                m_done = 0;
                if (start) begin
                    m_busy = 1; m_cnt = 0;
                    for (int c = 0; c < N; c++) begin m_code[c] = 0; m_cap[c] = 0; m_ovf[c] = 0; end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            int bad_code, bad_ovf;
            bad_code = -1; bad_ovf = -1;
            chk_eq("R3 ramp vs model", int'(ramp), m_cnt);
            chk_eq("R8 busy vs model", int'(busy), int'(m_busy));
            chk_eq("R8 done vs model", int'(done), int'(m_done));
            for (int c = N-1; c >= 0; c--) begin
                if (cell_code(c) != m_code[c]) bad_code = c;
                if (int'(ovf[c]) != int'(m_ovf[c])) bad_ovf = c;
            end
            if (bad_code >= 0) chk_eq("R4 cell code vs model", cell_code(bad_code), m_code[bad_code]);
            else chk_eq("R4 cell codes vs model", 0, 0);
            if (bad_ovf >= 0) chk_eq("R7 overrange vs model", int'(ovf[bad_ovf]), int'(m_ovf[bad_ovf]));
            else chk_eq("R7 overrange vs model", 0, 0);
        end
    end

    task automatic wait_ramp(input int v);
        do @(negedge clk); while (int'(ramp) != v);
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        int snap[N];
        // R1
        repeat (3) @(negedge clk);
        chk_eq("R1 busy in reset", int'(busy), 0);
        chk_eq("R1 done in reset", int'(done), 0);
        chk_eq("R1 ramp in reset", int'(ramp), 0);
        chk_eq("R1 codes in reset", int'(code != '0), 0);
        chk_eq("R1 ovf in reset", int'(ovf), 0);
        rst_n = 1'b1;
        model_on = 1'b1;
        @(negedge clk);
        chk_eq("R1 busy after reset", int'(busy), 0);
        chk_eq("R1 codes after reset", int'(code != '0), 0);
        cmp[14] = 1'b1;               // R6: high before start
        repeat (5) @(negedge clk);

        // Conversion 1
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk_eq("R2 busy after start", int'(busy), 1);
        chk_eq("R2 ramp after start", int'(ramp), 0);
        chk_eq("R2 ovf after start", int'(ovf), 0);
        wait_ramp(10);  cmp[0] = 1'b1;
        wait_ramp(20);  cmp[0] = 1'b0;
        wait_ramp(30);  cmp[0] = 1'b1;  // R5: second rise ignored
        for (int i = 1; i <= 10; i++) begin
            wait_ramp(i * 300); cmp[i] = 1'b1;
            if (i == 3) begin
                wait_ramp(1000); start = 1'b1;
                @(negedge clk); start = 1'b0;
                chk_eq("R9 busy after start while busy", int'(busy), 1);
                chk_eq("R9 ramp after start while busy", int'(ramp), 1001);
            end
        end
        wait_ramp(3500); cmp[11] = 1'b1; cmp[12] = 1'b1;
        wait_ramp(4093); cmp[13] = 1'b1;
        wait_done();
        chk_eq("R8 busy low with done", int'(busy), 0);
        chk_eq("R5 cell0 first edge only", cell_code(0), 12);
        for (int i = 1; i <= 10; i++) chk_eq("R4 cell code", cell_code(i), i * 300 + 2);
        chk_eq("R4 parallel cell11", cell_code(11), 3502);
        chk_eq("R4 parallel cell12", cell_code(12), 3502);
        chk_eq("R7 late cell code", cell_code(13), MAX);
        chk_eq("R7 late cell ovf clear", int'(ovf[13]), 0);
        chk_eq("R7 silent cell code", cell_code(15), MAX);
        chk_eq("R7 silent cell ovf", int'(ovf[15]), 1);
        chk_eq("R6 held-high cell ovf", int'(ovf[14]), 1);
        chk_eq("R6 held-high cell code", cell_code(14), MAX);
        @(negedge clk);
        chk_eq("R8 done one cycle", int'(done), 0);

        // R10: idle comparator activity changes nothing
        for (int c = 0; c < N; c++) snap[c] = cell_code(c);
        cmp = '0; repeat (4) @(negedge clk);
        cmp = '1; repeat (4) @(negedge clk);
        cmp = '0; repeat (6) @(negedge clk);
        for (int c = 0; c < N; c++) chk_eq("R10 code held in idle", cell_code(c), snap[c]);
        chk_eq("R10 ovf held in idle", int'(ovf), int'(16'hC000));

        // Conversion 2: all cells together
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk_eq("R2 codes cleared on start", int'(code != '0), 0);
        chk_eq("R2 ovf cleared on start", int'(ovf), 0);
        wait_ramp(100); cmp = '1;
        wait_done();
        for (int c = 0; c < N; c++) chk_eq("R4 all cells same code", cell_code(c), 102);
        chk_eq("R7 no overrange", int'(ovf), 0);
        repeat (3) @(negedge clk);
        report();
    end
endmodule